// File: doc/BRIEF.md
# Floating-Point Issue Interval Scoreboard

This block decides, cycle by cycle, whether one floating-point operation may issue to a set of execution units. The units differ in result latency, and some are only partly pipelined. The block tracks two kinds of timer. The first kind is per operation class and counts down the repeat interval before the same class may start again. The second kind is per destination tag and counts down the cycles until a dependent instruction may read that tag's result.

A requester presents an operation class, a destination tag and two source tags, and holds the request until it sees `grant`. The grant is decided in the same cycle from registered timer state. There are three reasons to stall. The class may still be inside its repeat interval. A source may still be in flight. Or an older operation writing the same destination may still be pending and due to complete no earlier than the new one would. The per-tag ready vector tells the rest of the pipeline which results can be read now.

Top module: `fpsb_scoreboard`

## Requirements
- R1: After reset every bit of `tag_ready` is 1, no class is inside a repeat interval, and a valid request with a legal class is granted in the first cycle.
- R2: Class codes map to (result latency, repeat interval) as follows: 0 add/subtract (4,3), 1 multiply (8,4), 2 divide (36,35), 3 square root (112,111), 4 negate/absolute (2,1), 5 compare (3,2). Codes 6 and 7 are never granted.
- R3: If an operation of class c is granted in cycle t, no other class-c request is granted in cycles t+1 to t+II(c)-1. A waiting class-c request with no other hazard is granted in cycle t+II(c).
- R4: If a grant in cycle t writes tag d, `tag_ready[d]` is 0 from cycle t+1 through t+LAT-1 and returns to 1 in cycle t+LAT.
- R5: A request is not granted while `tag_ready` is 0 for either of its source tags.
- R6: A request whose destination has a pending result due at or after the cycle in which the new result would be due is stalled. It is granted once the older result is due strictly earlier.
- R7: Different classes do not share repeat timers. An operation of another class may be granted in the cycle right after a grant.
- R8: `grant` is 0 whenever `req_valid` is 0, and at most one operation issues per cycle.
- R9: Timers stop at zero. A tag that is ready stays ready through any number of idle cycles until it is written again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Issue request present |
| req_class | input | 3 | Operation class code (see R2) |
| req_dst | input | TAG_W | Destination tag |
| req_src_a | input | TAG_W | First source tag |
| req_src_b | input | TAG_W | Second source tag |
| grant | output | 1 | Request issues this cycle |
| tag_ready | output | NUM_TAGS | Per-tag result-available flags |

## Verification
The hardest case to reach from the ports is the write-after-write stall. A long operation must still be in flight to a destination while a much shorter one aims at the same destination. The share of the long timer that is left must also sit exactly on the boundary where the short result would no longer complete later. The stimulus issues a divide to a tag and then holds a negate to that same tag. The negate can only go out once the divide has 1 cycle left, and the bench checks that the wait is exactly 35 cycles. A cycle-accurate behavioural model compares `grant` and the whole ready vector on every cycle of every sequence, including the long square-root and divide repeat intervals.

// File: rtl/fpsb_pkg.sv
package fpsb_pkg;
  localparam int CLS_W   = 3;
  localparam int NUM_CLS = 6;
  localparam int MAX_LAT = 112;
  localparam int CNT_W   = $clog2(MAX_LAT + 1);

  typedef enum logic [CLS_W-1:0] {
    CL_ADD  = 3'd0,
    CL_MUL  = 3'd1,
    CL_DIV  = 3'd2,
    CL_SQRT = 3'd3,
    CL_MOVE = 3'd4,
    CL_CMP  = 3'd5
  } fp_cls_e;

  // cycles until a dependent op may read the result
  function automatic logic [CNT_W-1:0] lat_of(input logic [CLS_W-1:0] c);
    case (c)
      CL_ADD:  lat_of = CNT_W'(4);
      CL_MUL:  lat_of = CNT_W'(8);
      CL_DIV:  lat_of = CNT_W'(36);
      CL_SQRT: lat_of = CNT_W'(112);
      CL_MOVE: lat_of = CNT_W'(2);
      CL_CMP:  lat_of = CNT_W'(3);
      default: lat_of = CNT_W'(1);
    endcase
  endfunction

  // cycles until another op of the same class may start
  function automatic logic [CNT_W-1:0] ii_of(input logic [CLS_W-1:0] c);
    case (c)
      CL_ADD:  ii_of = CNT_W'(3);
      CL_MUL:  ii_of = CNT_W'(4);
      CL_DIV:  ii_of = CNT_W'(35);
      CL_SQRT: ii_of = CNT_W'(111);
      CL_MOVE: ii_of = CNT_W'(1);
      CL_CMP:  ii_of = CNT_W'(2);
      default: ii_of = CNT_W'(1);
    endcase
  endfunction
endpackage

// File: rtl/fpsb_class_timer.sv
module fpsb_class_timer
  import fpsb_pkg::*;
#(
  parameter int N_CLS = NUM_CLS,
  parameter int CW    = CNT_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             fire,
  input  logic [CLS_W-1:0] fire_cls,
  output logic [N_CLS-1:0] busy
);
  logic [N_CLS-1:0][CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else begin
      for (int c = 0; c < N_CLS; c++) begin
        if (fire && fire_cls == CLS_W'(c))
          cnt_q[c] <= CW'(ii_of(CLS_W'(c)) - 1'b1);
        else if (cnt_q[c] != '0)
          cnt_q[c] <= cnt_q[c] - 1'b1;
      end
    end
  end

  for (genvar g = 0; g < N_CLS; g++) begin : g_busy
    assign busy[g] = (cnt_q[g] != '0);

    // R3: no start of a class while its repeat interval runs
    a_r3_hold_off: assert property (@(posedge clk) disable iff (rst)
      (cnt_q[g] != '0) |-> !(fire && fire_cls == CLS_W'(g)));
  end
endmodule

// File: rtl/fpsb_tag_timer.sv
module fpsb_tag_timer
  import fpsb_pkg::*;
#(
  parameter int N_TAGS = 16,
  parameter int TW     = $clog2(N_TAGS),
  parameter int CW     = CNT_W
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      load,
  input  logic [TW-1:0]             load_tag,
  input  logic [CW-1:0]             load_val,
  output logic [N_TAGS-1:0][CW-1:0] remain,
  output logic [N_TAGS-1:0]         ready
);
  always_ff @(posedge clk) begin
    if (rst) begin
      remain <= '0;
    end else begin
      for (int t = 0; t < N_TAGS; t++) begin
        if (load && load_tag == TW'(t))
          remain[t] <= load_val;
        else if (remain[t] != '0)
          remain[t] <= remain[t] - 1'b1;
      end
    end
  end

  for (genvar g = 0; g < N_TAGS; g++) begin : g_rdy
    assign ready[g] = (remain[g] == '0);

    // R9: an idle ready tag stays ready
    a_r9_floor: assert property (@(posedge clk) disable iff (rst)
      (remain[g] == '0 && !(load && load_tag == TW'(g))) |=> (remain[g] == '0));
  end
endmodule

// File: rtl/fpsb_issue.sv
module fpsb_issue
  import fpsb_pkg::*;
#(
  parameter int N_CLS  = NUM_CLS,
  parameter int N_TAGS = 16,
  parameter int TW     = $clog2(N_TAGS),
  parameter int CW     = CNT_W
) (
  input  logic                      req_valid,
  input  logic [CLS_W-1:0]          req_class,
  input  logic [TW-1:0]             req_dst,
  input  logic [TW-1:0]             req_src_a,
  input  logic [TW-1:0]             req_src_b,
  input  logic [N_CLS-1:0]          class_busy,
  input  logic [N_TAGS-1:0][CW-1:0] remain,
  output logic                      grant,
  output logic [CW-1:0]             lat
);
  localparam int CODES = 2 ** CLS_W;

  logic [CODES-1:0] busy_pad;
  logic             legal, src_wait, waw_wait;

  always_comb begin
    busy_pad = CODES'(class_busy);
    legal    = (int'(req_class) < N_CLS);
    lat      = CW'(lat_of(req_class));
    src_wait = (remain[req_src_a] != '0) || (remain[req_src_b] != '0);
    waw_wait = (remain[req_dst] >= lat);
    grant    = req_valid && legal && !busy_pad[req_class] && !src_wait && !waw_wait;
  end
endmodule

// File: rtl/fpsb_scoreboard.sv
module fpsb_scoreboard
  import fpsb_pkg::*;
#(
  parameter int NUM_TAGS = 16,
  parameter int TAG_W    = $clog2(NUM_TAGS)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                req_valid,
  input  logic [CLS_W-1:0]    req_class,
  input  logic [TAG_W-1:0]    req_dst,
  input  logic [TAG_W-1:0]    req_src_a,
  input  logic [TAG_W-1:0]    req_src_b,
  output logic                grant,
  output logic [NUM_TAGS-1:0] tag_ready
);
  logic [NUM_CLS-1:0]                class_busy;
  logic [NUM_TAGS-1:0][CNT_W-1:0]    remain;
  logic [CNT_W-1:0]                  lat;

  fpsb_class_timer #(.N_CLS(NUM_CLS), .CW(CNT_W)) u_cls (
    .clk(clk), .rst(rst), .fire(grant), .fire_cls(req_class), .busy(class_busy)
  );

  fpsb_tag_timer #(.N_TAGS(NUM_TAGS), .TW(TAG_W), .CW(CNT_W)) u_tag (
    .clk(clk), .rst(rst), .load(grant), .load_tag(req_dst),
    .load_val(CNT_W'(lat - 1'b1)), .remain(remain), .ready(tag_ready)
  );

  fpsb_issue #(.N_CLS(NUM_CLS), .N_TAGS(NUM_TAGS), .TW(TAG_W), .CW(CNT_W)) u_iss (
    .req_valid(req_valid), .req_class(req_class), .req_dst(req_dst),
    .req_src_a(req_src_a), .req_src_b(req_src_b), .class_busy(class_busy),
    .remain(remain), .grant(grant), .lat(lat)
  );

  // R5: sources must be readable at issue
  a_r5_src_ready: assert property (@(posedge clk) disable iff (rst)
    grant |-> (tag_ready[req_src_a] && tag_ready[req_src_b]));

  // R2: illegal class codes never issue
  a_r2_class_range: assert property (@(posedge clk) disable iff (rst)
    grant |-> (int'(req_class) < NUM_CLS));

  // R4: destination reads busy the cycle after issue
  a_r4_dst_busy: assert property (@(posedge clk) disable iff (rst)
    grant |=> !tag_ready[$past(req_dst)]);

  // R8: no issue without a request
  a_r8_need_valid: assert property (@(posedge clk) disable iff (rst)
    !req_valid |-> !grant);
endmodule

// File: tb/fpsb_scoreboard_bench.sv
`timescale 1ns/1ps
module fpsb_scoreboard_bench;
  localparam int NT = 16;
  localparam int TW = 4;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          req_valid = 1'b0;
  logic [2:0]    req_class = '0;
  logic [TW-1:0] req_dst = '0, req_src_a = '0, req_src_b = '0;
  logic          grant;
  logic [NT-1:0] tag_ready;

  fpsb_scoreboard #(.NUM_TAGS(NT), .TAG_W(TW)) u_fpsb_scoreboard (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_class(req_class),
    .req_dst(req_dst), .req_src_a(req_src_a), .req_src_b(req_src_b),
    .grant(grant), .tag_ready(tag_ready)
  );

  always #10 clk = ~clk;

  int LAT[6] = '{4, 8, 36, 112, 2, 3};
  int II[6]  = '{3, 4, 35, 111, 1, 2};
  int cls_free[6];
  int tag_due[NT];
  int cyc = 0;
  int checks = 0;
  int fails = 0;

  task automatic check(input bit ok, input string rq, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", rq, act, exp, cyc);
    end
  endtask

  task automatic step(input bit v, input int cls, input int dst, input int sa,
                      input int sb, input string rq, output bit g, output int gc);
    bit exp_g;
    logic [NT-1:0] exp_m;
    @(negedge clk);
    req_valid = v; req_class = 3'(cls); req_dst = TW'(dst);
    req_src_a = TW'(sa); req_src_b = TW'(sb);
    #8;
    exp_g = v && cls < 6;
    if (exp_g)
      exp_g = cyc >= cls_free[cls] && cyc >= tag_due[sa] && cyc >= tag_due[sb]
              && (tag_due[dst] - cyc) < LAT[cls];
    for (int t = 0; t < NT; t++) exp_m[t] = (cyc >= tag_due[t]);
    check(grant === exp_g, {rq, " grant"}, int'(grant), int'(exp_g));
    check(tag_ready === exp_m, "R4 tag_ready", int'(tag_ready), int'(exp_m));
    g = grant; gc = cyc;
    @(posedge clk);
    if (exp_g) begin
      cls_free[cls] = cyc + II[cls];
      tag_due[dst]  = cyc + LAT[cls];
    end
    cyc++;
  endtask

  task automatic issue(input int cls, input int dst, input int sa, input int sb,
                       input string rq, output int gc);
    bit g = 0;
    int k = 0;
    gc = -1;
    while (!g && k < 300) begin
      step(1, cls, dst, sa, sb, rq, g, gc);
      k++;
    end
    if (!g) gc = -1000;
  endtask

  task automatic idle(input int n);
    bit g; int gc;
    for (int i = 0; i < n; i++) step(0, 0, 0, 0, 0, "R9", g, gc);
  endtask

  task automatic burst(input int cls, input int gap, input int n, input int base, input string rq);
    int prev, now;
    issue(cls, base, 15, 15, rq, prev);
    for (int i = 1; i < n; i++) begin
      issue(cls, base + i, 15, 15, rq, now);
      check(now - prev == gap, {rq, " repeat gap"}, now - prev, gap);
      prev = now;
    end
  endtask

  initial begin
    #(20 * 200000);
    fails++; checks++;
    $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    bit g; int t0, t1;
    for (int c = 0; c < 6; c++) cls_free[c] = 0;
    for (int t = 0; t < NT; t++) tag_due[t] = 0;
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;

    // R1: granted at once after reset, all tags ready
    step(1, 0, 0, 15, 15, "R1", g, t0);
    check(g == 1, "R1 first grant", int'(g), 1);
    idle(6);

    // R3 / R2: repeat intervals per class
    burst(0, 3, 3, 1, "R3 add");
    burst(1, 4, 3, 4, "R3 mul");
    burst(5, 2, 3, 7, "R3 cmp");
    burst(4, 1, 3, 10, "R3 neg");
    burst(2, 35, 2, 0, "R2 div");
    idle(40);
    burst(3, 111, 2, 2, "R2 sqrt");
    idle(115);

    // R7: different classes back to back
    issue(0, 1, 15, 15, "R7", t0);
    issue(1, 2, 15, 15, "R7", t1);
    check(t1 - t0 == 1, "R7 mixed gap", t1 - t0, 1);
    idle(10);

    // R5: dependent add waits for multiply result
    issue(1, 5, 15, 15, "R5", t0);
    issue(0, 6, 14, 5, "R5", t1);
    check(t1 - t0 == 8, "R5 raw wait", t1 - t0, 8);
    idle(10);

    // R6: short op to the same destination as a divide
    issue(2, 7, 15, 15, "R6", t0);
    issue(4, 7, 15, 15, "R6", t1);
    check(t1 - t0 == 35, "R6 waw wait", t1 - t0, 35);
    idle(5);

    // R2: illegal codes never granted
    for (int i = 0; i < 4; i++) begin
      step(1, 6 + (i % 2), 3, 15, 15, "R2 illegal", g, t0);
      check(g == 0, "R2 illegal code", int'(g), 0);
    end

    // R8: no grant without valid
    for (int i = 0; i < 3; i++) begin
      step(0, 0, 3, 15, 15, "R8", g, t0);
      check(g == 0, "R8 no valid", int'(g), 0);
    end

    // R9: long idle keeps everything ready
    idle(20);
    check(tag_ready === '1, "R9 all ready", int'(tag_ready), 16'hFFFF);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule